// File: doc/BRIEF.md
# Debug Access Control and Status Word Pair

This block sits on the debugger side of a microcontroller and presents two 32-bit words. The debugger reads a status word that reports flash readiness, the security state, whether the system is out of reset, and the core's halt and low-power state. It also reads and writes a control word. Each control bit drives a request to another part of the chip: a flash mass erase, a debug disable, a halt request, a system reset hold, and a hold of the core in reset after reset sequencing.

The flash controller, the core, the reset sequencer and the debug wire transport are all outside the block. They appear as level inputs and outputs, plus a one-cycle erase-complete pulse. Access is a single-cycle strobe with a write flag, an address and write data. Read data returns on the clock after the strobe. When the device is secured, only the erase and reset-request bits accept writes.

Top module: `dbg_ctlstat`

## Requirements
- R1: Status word bit 1 equals `flash_ready_i`. Bit 3 is 1 when `sys_in_reset_i` is 0. Bits 16, 17 and 18 equal `core_halted_i`, `core_deepsleep_i` and `core_sleep_i`. Bits 0, 4 to 15 and 19 to 31 read 0.
- R2: Status bit 2 is 1 only when `secure_i` and `flash_ready_i` are both 1. While flash is not ready it reads 0.
- R3: Writing 1 to control bit 0 sets `erase_req_o` from the next clock. Software writes of 0 to that bit have no effect. The bit clears on the clock edge at which `erase_done_i` is high while it is set.
- R4: Control bit 1 set forces `dbg_enable_o` to 0. With the bit clear, `dbg_enable_o` follows `core_dbgen_i`.
- R5: Control bit 2 drives `halt_req_o`. `wake_req_o` is high when bit 2 is set and either `core_sleep_i` or `core_deepsleep_i` is high.
- R6: Control bit 3 drives `sys_rst_req_o` and holds it high until software writes the bit to 0.
- R7: `core_in_reset_o` is high while `sys_in_reset_i` is high or control bit 4 is set. A write clearing bit 4 drops it on the clock that takes the write.
- R8: The device counts as secured when `secure_i` and `flash_ready_i` are both 1. While it is secured, writes to control bits 1, 2 and 4 are ignored, and bits 0 and 3 still accept writes.
- R9: A control word read returns bits 0 to 4 as currently held, including bit 0 during an erase. Bits 5 to 31 read 0.
- R10: A read strobe at address 0 (status) or 1 (control) raises `rd_valid_o` for exactly the following cycle with the sampled word on `rd_data_o`. `rd_valid_o` is low after cycles with no read.
- R11: After reset the control word is zero and all request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Access strobe, one cycle per access |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | ADDR_W | Word select: 0 status, 1 control |
| acc_wdata_i | input | DATA_W | Write data |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | DATA_W | Read data |
| flash_ready_i | input | 1 | Flash controller ready |
| secure_i | input | 1 | Security state from flash |
| erase_done_i | input | 1 | Mass erase complete pulse |
| sys_in_reset_i | input | 1 | System currently in reset |
| core_dbgen_i | input | 1 | Core's own debug-enable setting |
| core_halted_i | input | 1 | Core halted in debug |
| core_deepsleep_i | input | 1 | Core in stop mode |
| core_sleep_i | input | 1 | Core in wait mode |
| erase_req_o | output | 1 | Mass erase request |
| dbg_enable_o | output | 1 | Effective debug enable |
| halt_req_o | output | 1 | Halt request to core |
| wake_req_o | output | 1 | Wake-to-halt request |
| sys_rst_req_o | output | 1 | System reset hold |
| core_in_reset_o | output | 1 | Core reset after sequencing |

## Verification
The bench builds the block with its default parameters: 32-bit words, a 4-bit address, status at address 0 and control at address 1. With these values the reserved-bit ranges of both words are fully populated. The secured write mask can then be exercised with an all-ones write, which shows that exactly bits 0 and 3 stick. The same settings let the erase handshake, the wake decode against both low-power inputs, and the core hold release be observed at the ports on the cycle each one is expected.

// File: rtl/dbg_cs_pkg.sv
package dbg_cs_pkg;

    localparam int CTL_ERASE    = 0;
    localparam int CTL_DBGDIS   = 1;
    localparam int CTL_HALT     = 2;
    localparam int CTL_SYSRST   = 3;
    localparam int CTL_COREHOLD = 4;
    localparam int CTL_NBITS    = 5;

    localparam int ST_FLASHRDY  = 1;
    localparam int ST_SECURE    = 2;
    localparam int ST_RUNNING   = 3;
    localparam int ST_HALTED    = 16;
    localparam int ST_DEEP      = 17;
    localparam int ST_SLEEP     = 18;
    localparam int ST_TOPBIT    = 18;

    // bits that accept writes while secured
    localparam logic [CTL_NBITS-1:0] CTL_SECURE_OK =
        (CTL_NBITS'(1) << CTL_ERASE) | (CTL_NBITS'(1) << CTL_SYSRST);

    typedef struct packed {
        logic core_hold;
        logic sys_rst;
        logic halt;
        logic dbg_dis;
        logic erase;
    } ctl_bits_t;

endpackage

// File: rtl/dbg_cs_ctl.sv
module dbg_cs_ctl
    import dbg_cs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              secured,
    input  logic              erase_done,
    output ctl_bits_t         ctl_o
);

    typedef struct packed {
        ctl_bits_t ctl;
    } state_t;

    state_t s_d, s_q;
    logic [CTL_NBITS-1:0] cur, wmask, nxt;

    always_comb begin
        s_d   = s_q;
        cur   = s_q.ctl;
        wmask = secured ? CTL_SECURE_OK : '1;
        nxt   = cur;
        if (wr_en) begin
            for (int b = 0; b < CTL_NBITS; b++) begin
                if (b != CTL_ERASE && wmask[b]) begin
                    nxt[b] = wdata[b];
                end
            end
            // erase bit: software can only start it
            if (wmask[CTL_ERASE] && wdata[CTL_ERASE] && !cur[CTL_ERASE]) begin
                nxt[CTL_ERASE] = 1'b1;
            end
        end
        if (cur[CTL_ERASE] && erase_done) begin
            nxt[CTL_ERASE] = 1'b0;
        end
        s_d.ctl = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctl_o = s_q.ctl;

endmodule

// File: rtl/dbg_cs_stat.sv
module dbg_cs_stat
    import dbg_cs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              flash_ready,
    input  logic              secure,
    input  logic              sys_in_reset,
    input  logic              halted,
    input  logic              deepsleep,
    input  logic              sleeping,
    output logic [DATA_W-1:0] word_o
);

    localparam int USED_W = ST_TOPBIT + 1;

    logic [USED_W-1:0] used;

    always_comb begin
        used              = '0;
        used[ST_FLASHRDY] = flash_ready;
        used[ST_SECURE]   = flash_ready & secure;
        used[ST_RUNNING]  = ~sys_in_reset;
        used[ST_HALTED]   = halted;
        used[ST_DEEP]     = deepsleep;
        used[ST_SLEEP]    = sleeping;
    end

    generate
        if (DATA_W > USED_W) begin : g_pad
            assign word_o = {{(DATA_W-USED_W){1'b0}}, used};
        end else begin : g_trim
            assign word_o = used[DATA_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/dbg_cs_rdport.sv
module dbg_cs_rdport #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] rd_word,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.vld = rd_en;
        if (rd_en) begin
            s_d.data = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_valid_o = s_q.vld;
    assign rd_data_o  = s_q.data;

endmodule

// File: rtl/dbg_ctlstat.sv
module dbg_ctlstat
    import dbg_cs_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int STAT_ADDR = 0,
    parameter int CTL_ADDR  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid_i,
    input  logic              acc_write_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [DATA_W-1:0] acc_wdata_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              flash_ready_i,
    input  logic              secure_i,
    input  logic              erase_done_i,
    input  logic              sys_in_reset_i,
    input  logic              core_dbgen_i,
    input  logic              core_halted_i,
    input  logic              core_deepsleep_i,
    input  logic              core_sleep_i,
    output logic              erase_req_o,
    output logic              dbg_enable_o,
    output logic              halt_req_o,
    output logic              wake_req_o,
    output logic              sys_rst_req_o,
    output logic              core_in_reset_o
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(CTL_ADDR);

    logic              hit_ctl, hit_stat, secured, wr_ctl, rd_any;
    ctl_bits_t         ctl_q;
    logic [DATA_W-1:0] stat_word, ctl_word, rd_word;

    assign hit_ctl  = acc_valid_i && (acc_addr_i == A_CTL);
    assign hit_stat = acc_valid_i && (acc_addr_i == A_STAT);
    assign secured  = secure_i & flash_ready_i;
    assign wr_ctl   = hit_ctl && acc_write_i;
    assign rd_any   = (hit_ctl || hit_stat) && !acc_write_i;

    dbg_cs_ctl #(.DATA_W(DATA_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_ctl),
        .wdata      (acc_wdata_i),
        .secured    (secured),
        .erase_done (erase_done_i),
        .ctl_o      (ctl_q)
    );

    dbg_cs_stat #(.DATA_W(DATA_W)) u_stat (
        .flash_ready  (flash_ready_i),
        .secure       (secure_i),
        .sys_in_reset (sys_in_reset_i),
        .halted       (core_halted_i),
        .deepsleep    (core_deepsleep_i),
        .sleeping     (core_sleep_i),
        .word_o       (stat_word)
    );

    assign ctl_word = {{(DATA_W-CTL_NBITS){1'b0}}, ctl_q};
    assign rd_word  = hit_ctl ? ctl_word : stat_word;

    dbg_cs_rdport #(.DATA_W(DATA_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_any),
        .rd_word    (rd_word),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o)
    );

    assign erase_req_o     = ctl_q.erase;
    assign dbg_enable_o    = core_dbgen_i & ~ctl_q.dbg_dis;
    assign halt_req_o      = ctl_q.halt;
    assign wake_req_o      = ctl_q.halt & (core_sleep_i | core_deepsleep_i);
    assign sys_rst_req_o   = ctl_q.sys_rst;
    assign core_in_reset_o = sys_in_reset_i | ctl_q.core_hold;

endmodule

// File: rtl/dbg_ctlstat_chk.sv
module dbg_ctlstat_chk
    import dbg_cs_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4,
    parameter int CTL_ADDR = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid_i,
    input logic              acc_write_i,
    input logic [ADDR_W-1:0] acc_addr_i,
    input logic              rd_valid_o,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              flash_ready_i,
    input logic              secure_i,
    input logic              erase_done_i,
    input logic              sys_in_reset_i,
    input logic              erase_req_o,
    input logic              halt_req_o,
    input logic              wake_req_o,
    input logic              core_in_reset_o,
    input ctl_bits_t         ctl_q
);

    function automatic logic [DATA_W-1:0] rsvd_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if ((i >= CTL_NBITS && i < ST_HALTED) || i > ST_TOPBIT) m[i] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] RSVD = rsvd_mask();

    logic sec_wr;
    assign sec_wr = acc_valid_i && acc_write_i && (acc_addr_i == ADDR_W'(CTL_ADDR))
                    && flash_ready_i && secure_i;

    AST_ERASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req_o && !erase_done_i) |=> erase_req_o); // R3
    AST_ERASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req_o && erase_done_i) |=> !erase_req_o); // R3
    AST_SECURE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_wr |=> ($stable(ctl_q.dbg_dis) && $stable(ctl_q.halt) && $stable(ctl_q.core_hold))); // R8
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> ((rd_data_o & RSVD) == '0)); // R9
    AST_READ_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && !acc_write_i && acc_addr_i < ADDR_W'(2)) |=> rd_valid_o); // R10
    AST_WAKE_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |-> halt_req_o); // R5
    AST_CORE_FOLLOWS_SYS: assert property (@(posedge clk) disable iff (!rst_n)
        sys_in_reset_i |-> core_in_reset_o); // R7

endmodule

bind dbg_ctlstat dbg_ctlstat_chk #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .CTL_ADDR (CTL_ADDR)
) chk_i (.*);

// File: tb/dbg_ctlstat_tb_top.sv
module dbg_ctlstat_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid_i = 1'b0, acc_write_i = 1'b0;
    logic [3:0]  acc_addr_i = '0;
    logic [31:0] acc_wdata_i = '0;
    logic        rd_valid_o;
    logic [31:0] rd_data_o;
    logic        flash_ready_i = 1'b0, secure_i = 1'b0, erase_done_i = 1'b0;
    logic        sys_in_reset_i = 1'b1, core_dbgen_i = 1'b1;
    logic        core_halted_i = 1'b0, core_deepsleep_i = 1'b0, core_sleep_i = 1'b0;
    logic        erase_req_o, dbg_enable_o, halt_req_o, wake_req_o;
    logic        sys_rst_req_o, core_in_reset_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    dbg_ctlstat dut_i (.*);

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input int addr, input logic [31:0] d);
        @(negedge clk);
        acc_valid_i = 1'b1;
        acc_write_i = wr;
        acc_addr_i  = 4'(addr);
        acc_wdata_i = d;
        @(negedge clk);
        acc_valid_i = 1'b0;
        acc_write_i = 1'b0;
    endtask

    task automatic rd(input int addr, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        access(1'b0, addr, '0);
    endtask

    task automatic wr(input logic [31:0] d);
        access(1'b1, 1, d);
    endtask

    task automatic pulse_done();
        @(negedge clk);
        erase_done_i = 1'b1;
        @(negedge clk);
        erase_done_i = 1'b0;
    endtask

    // monitor: compare returned read data against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rd_valid_o) begin
            if (exp_q.size() == 0) begin
                check(rd_data_o, 32'hDEAD_BEEF, "R10 unexpected read data");
            end else begin
                check(rd_data_o, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check({26'd0, erase_req_o, halt_req_o, wake_req_o, sys_rst_req_o, ~dbg_enable_o, rd_valid_o}, 0, "R11 outputs after reset");
        check({31'd0, core_in_reset_o}, 1, "R7 core in reset during system reset");
        rd(1, 32'h0, "R11 control word after reset");
        rd(0, 32'h0, "R1 status during system reset");

        sys_in_reset_i = 1'b0; flash_ready_i = 1'b1;
        core_halted_i = 1'b1; core_sleep_i = 1'b1;
        rd(0, 32'h0005_000A, "R1 status mirrors inputs");
        @(negedge clk);
        check({31'd0, rd_valid_o}, 0, "R10 no valid without read");
        core_sleep_i = 1'b0; core_deepsleep_i = 1'b1; core_halted_i = 1'b0;
        rd(0, 32'h0002_000A, "R1 deep sleep status");
        core_deepsleep_i = 1'b0;

        secure_i = 1'b1;
        rd(0, 32'h0000_000E, "R2 secured status");
        flash_ready_i = 1'b0;
        rd(0, 32'h0000_0008, "R2 security ignored before flash ready");
        flash_ready_i = 1'b1;

        // secured: only bits 0 and 3 take writes
        wr(32'hFFFF_FFFF);
        rd(1, 32'h0000_0009, "R8 secured write mask");
        check({31'd0, halt_req_o}, 0, "R8 halt blocked while secured");
        check({31'd0, dbg_enable_o}, 1, "R8 debug disable blocked while secured");
        check({31'd0, core_in_reset_o}, 0, "R8 core hold blocked while secured");
        check({31'd0, sys_rst_req_o}, 1, "R6 reset request set");
        check({31'd0, erase_req_o}, 1, "R3 erase started");
        pulse_done();
        check({31'd0, erase_req_o}, 0, "R3 erase cleared by done");
        check({31'd0, sys_rst_req_o}, 1, "R6 reset request still held");
        wr(32'h0);
        check({31'd0, sys_rst_req_o}, 0, "R6 reset request released");

        secure_i = 1'b0;
        wr(32'h2);
        check({31'd0, dbg_enable_o}, 0, "R4 debug disabled");
        core_sleep_i = 1'b1;
        wr(32'h4);
        check({31'd0, dbg_enable_o}, 1, "R4 debug re-enabled");
        check({30'd0, halt_req_o, wake_req_o}, 3, "R5 halt and wake from wait");
        core_sleep_i = 1'b0; core_deepsleep_i = 1'b1;
        @(negedge clk);
        check({31'd0, wake_req_o}, 1, "R5 wake from stop");
        core_deepsleep_i = 1'b0;
        @(negedge clk);
        check({30'd0, halt_req_o, wake_req_o}, 2, "R5 halt without wake when running");

        wr(32'h10);
        check({31'd0, core_in_reset_o}, 1, "R7 core held");
        rd(1, 32'h0000_0010, "R9 control read core hold");
        wr(32'h0);
        check({31'd0, core_in_reset_o}, 0, "R7 core released on clearing write");

        wr(32'h1);
        wr(32'h0);
        check({31'd0, erase_req_o}, 1, "R3 software zero ignored during erase");
        rd(1, 32'h0000_0001, "R9 erase bit visible while in progress");
        pulse_done();
        rd(1, 32'h0000_0000, "R3 erase bit cleared");

        repeat (2) @(negedge clk);
        check(exp_q.size(), 0, "R10 all reads returned");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule